// File: doc/BRIEF.md
# Sensor bus slave protocol responder

This block is the protocol half of a sensor node that sits on a single-wire, pulse-duration-coded management bus. A line interface measures the low pulses on the wire and hands over one decoded symbol per pulse. From that symbol stream the responder decodes frames, decides whether the frame is meant for it, and serves reads and writes to the small set of registers every node must carry. It also tells the line interface when to drive a slot (read data, read parity, write acknowledge), when to hold the wire low for its power-up bus reset, and when to emit an attention request.

A frame begins with a start symbol. It then carries a 3-bit device field, a 6-bit register address and a direction bit (1 = read), all sent MSB first. Next come DATA_W data bits, MSB first, and an even-parity bit. The parity covers every bit from the device field to the last data bit. An acknowledge slot closes the frame, with D1 as the positive acknowledge. On a write the master drives data and parity and the node drives the acknowledge. On a read the node drives data and parity and the master drives the acknowledge. Symbol codes on `sym_i` are D0=0, D1=1, START=2, ATTN=3, RST=4. When the node does not drive a slot, the slot reads as D0.

Register addresses 8 to 31 form three windows of eight registers, one per sensor function. The windows up to NUM_FUNC are passed to the function logic through a plain address/data port. The measurement functions themselves live outside the block.

Top module: `snr_resp`

## Requirements
- R1: After `rst_ni` is released, `rst_drv_o` stays high for exactly POR_CYC clock cycles. Symbols that arrive during that time are ignored, so no slot is driven once it ends.
- R2: A read is answered only when the device field equals `dev_num_i`, and never for device 0. A write is taken when the device field equals `dev_num_i` or is 0 (broadcast). A frame for another device gets no slot driven and no register change.
- R3: Read values follow this map. Address 0 holds `dev_num_i` in bits 2:0. Address 1 holds MFG_ID. Address 2 holds DEV_ID (revision in 15:11, code in 10:0). Address 3 holds CAP_FIXED. Address 4 holds the status byte {bus error in bit 7, `func_status_i` in bits 6:0}. Address 5 holds the control register. The node drives all DATA_W data slots MSB first, then an even-parity slot.
- R4: A write to address 5 with good parity is acknowledged by driving D1 in the acknowledge slot. `ctrl_o` takes the data only after the acknowledge slot is seen as D1.
- R5: A write whose parity bit does not give even parity is not acknowledged: no drive in the acknowledge slot, and no register or function write.
- R6: Reads of addresses 6, 7, 32 to 63 and of windows above NUM_FUNC return zero. Writes to them are acknowledged and change nothing.
- R7: A start symbol in the middle of a frame drops that frame and begins a new header. No attention request results.
- R8: There is no timeout between symbols. A frame completes correctly after an arbitrary gap.
- R9: A read whose acknowledge slot is not D1 sets the bus error bit and queues an attention request. `attn_o` pulses for one cycle, and only while `bus_idle_i` is high.
- R10: If the acknowledge the node drives on a write is seen as anything other than D1, the node sets the bus error bit, queues an attention request and does not commit the write.
- R11: A RST symbol returns frame decoding to idle at once. Register contents, including the control register, are kept.
- R12: A status read that completes with a positive acknowledge returns bus error = 1 if it was set, and then clears it.
- R13: An ATTN symbol in a master-driven bit slot is skipped without counting as a bit, so the frame proceeds as if it were absent.
- R14: Writes to addresses in windows 1 to NUM_FUNC pulse `fn_wr_o` with `fn_addr_o` and `fn_wdata_o`. Reads of those addresses return `fn_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| dev_num_i | input | 3 | Strapped device number, 1 to 7 |
| sym_vld_i | input | 1 | One-cycle strobe: a symbol was decoded on the line |
| sym_i | input | 3 | Decoded symbol code |
| bus_idle_i | input | 1 | Line has been idle long enough to start an attention request |
| rst_drv_o | output | 1 | Hold the line low as the power-up bus reset |
| slot_drv_o | output | 1 | Node drives the current bit slot |
| slot_bit_o | output | 1 | Value to drive in that slot |
| attn_o | output | 1 | One-cycle request to send an attention symbol |
| ctrl_o | output | DATA_W | Control register contents |
| func_status_i | input | 7 | Function status flags shown in the status register |
| fn_addr_o | output | 6 | Register address toward the function logic |
| fn_wr_o | output | 1 | Write strobe to a function window |
| fn_wdata_o | output | DATA_W | Write data to the function logic |
| fn_rdata_i | input | DATA_W | Read data from the function logic at `fn_addr_o` |

## Verification
Reads of every mandatory register check the driven data and the parity slot, so a wrong register map or a parity error shows up directly. Writes are tried with good parity, with a flipped parity bit, to another device, to broadcast, to reserved addresses and to function windows, which separates address matching, parity gating and address decoding. Frames are also broken up on purpose: by a mid-frame start, a bus reset, a long gap and a stray attention symbol. These show whether the decoder restarts, waits or skips in each case. Failed acknowledges on both reads and writes are followed by probes of `attn_o` with the bus idle and busy, and by status reads that show the bus error bit being set and then cleared.

// File: rtl/snr_pkg.sv
package snr_pkg;
  localparam int DEV_W = 3;
  localparam int REG_W = 6;
  localparam int SYM_W = 3;
  localparam int HDR_W = DEV_W + REG_W + 1;

  typedef enum logic [SYM_W-1:0] {
    SYM_D0    = 3'd0,
    SYM_D1    = 3'd1,
    SYM_START = 3'd2,
    SYM_ATTN  = 3'd3,
    SYM_RST   = 3'd4
  } sym_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_WDAT, ST_WPAR, ST_WACK,
    ST_RDAT, ST_RPAR, ST_RACK, ST_SKIP
  } st_e;
endpackage

// File: rtl/snr_frame.sv
module snr_frame
  import snr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sym_vld_i,
  input  sym_e              sym_i,
  input  logic [DEV_W-1:0]  dev_num_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [REG_W-1:0]  addr_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_done_o,
  output logic              err_o,
  output logic              bus_rst_o,
  output logic              slot_drv_o,
  output logic              slot_bit_o
);
  localparam int MAXW  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int CNT_W = $clog2(MAXW);

  st_e                      st_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [DEV_W+REG_W-1:0]   hdr_q;
  logic [DATA_W-1:0]        sh_q;
  logic                     par_q, par_ok_q;

  logic             is_bit, b;
  logic [DEV_W-1:0] dev;
  logic             hit_rd, hit_wr;

  assign is_bit = (sym_i == SYM_D0) || (sym_i == SYM_D1);
  assign b      = (sym_i == SYM_D1);
  assign dev    = hdr_q[REG_W +: DEV_W];
  assign hit_wr = (dev == dev_num_i) || (dev == '0);
  assign hit_rd = (dev == dev_num_i) && (dev != '0);

  assign addr_o    = hdr_q[REG_W-1:0];
  assign wdata_o   = sh_q;
  assign bus_rst_o = en_i && sym_vld_i && (sym_i == SYM_RST);

  always_comb begin
    slot_drv_o = 1'b0;
    slot_bit_o = 1'b1;
    if (en_i) begin
      unique case (st_q)
        ST_RDAT: begin slot_drv_o = 1'b1; slot_bit_o = sh_q[DATA_W-1]; end
        ST_RPAR: begin slot_drv_o = 1'b1; slot_bit_o = par_q; end
        ST_WACK: slot_drv_o = par_ok_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      par_ok_q  <= 1'b0;
      wr_o      <= 1'b0;
      rd_done_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      wr_o      <= 1'b0;
      rd_done_o <= 1'b0;
      err_o     <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else if (sym_vld_i) begin
        if (sym_i == SYM_RST) begin
          st_q <= ST_IDLE;
        end else if (sym_i == SYM_START) begin
          st_q  <= ST_HDR;
          cnt_q <= '0;
          par_q <= 1'b0;
        end else begin
          unique case (st_q)
            ST_HDR: if (is_bit) begin
              par_q <= par_q ^ b;
              if (cnt_q == CNT_W'(HDR_W-1)) begin
                cnt_q <= '0;
                if (b && hit_rd) begin
                  sh_q  <= rd_data_i;
                  par_q <= par_q ^ b ^ (^rd_data_i);
                  st_q  <= ST_RDAT;
                end else if (!b && hit_wr) begin
                  st_q <= ST_WDAT;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else begin
                hdr_q <= {hdr_q[DEV_W+REG_W-2:0], b};
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_WDAT: if (is_bit) begin
              sh_q  <= {sh_q[DATA_W-2:0], b};
              par_q <= par_q ^ b;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(DATA_W-1)) st_q <= ST_WPAR;
            end
            ST_WPAR: if (is_bit) begin
              par_ok_q <= (b == par_q);
              st_q     <= ST_WACK;
            end
            ST_WACK: begin
              // any symbol ends the frame; a driven ack seen as non-D1 is a disruption
              st_q <= ST_IDLE;
              if (par_ok_q) begin
                if (b) wr_o  <= 1'b1;
                else   err_o <= 1'b1;
              end
            end
            ST_RDAT: if (is_bit) begin
              sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(DATA_W-1)) st_q <= ST_RPAR;
            end
            ST_RPAR: if (is_bit) st_q <= ST_RACK;
            ST_RACK: begin
              st_q <= ST_IDLE;
              if (b) rd_done_o <= 1'b1;
              else   err_o     <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_START_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sym_vld_i && sym_i == SYM_START) |=> !slot_drv_o); // R7
  AST_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |=> (!slot_drv_o && !wr_o)); // R11
endmodule

// File: rtl/snr_regs.sv
module snr_regs
  import snr_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              NUM_FUNC  = 2,
  parameter logic [DATA_W-1:0] MFG_ID    = 16'hA5C3,
  parameter logic [DATA_W-1:0] DEV_ID    = 16'h1123,
  parameter logic [DATA_W-1:0] CAP_FIXED = 16'h0021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DEV_W-1:0]  dev_num_i,
  input  logic [REG_W-1:0]  addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_done_i,
  input  logic              err_i,
  input  logic [6:0]        func_status_i,
  input  logic [DATA_W-1:0] fn_rdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [REG_W-1:0]  fn_addr_o,
  output logic              fn_wr_o,
  output logic [DATA_W-1:0] fn_wdata_o
);
  localparam int          NWIN     = 3;
  localparam logic [REG_W-1:0] A_DEV  = 6'd0;
  localparam logic [REG_W-1:0] A_MFG  = 6'd1;
  localparam logic [REG_W-1:0] A_ID   = 6'd2;
  localparam logic [REG_W-1:0] A_CAP  = 6'd3;
  localparam logic [REG_W-1:0] A_STAT = 6'd4;
  localparam logic [REG_W-1:0] A_CTRL = 6'd5;

  logic [NWIN-1:0]   win_hit;
  logic              ber_q;
  logic [DATA_W-1:0] ctrl_q;

  for (genvar f = 0; f < NWIN; f++) begin : g_win
    assign win_hit[f] = (f < NUM_FUNC) && (addr_i[REG_W-1:3] == 3'(f + 1));
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_DEV:  rd_data_o[DEV_W-1:0] = dev_num_i;
      A_MFG:  rd_data_o = MFG_ID;
      A_ID:   rd_data_o = DEV_ID;
      A_CAP:  rd_data_o = CAP_FIXED;
      A_STAT: rd_data_o[7:0] = {ber_q, func_status_i};
      A_CTRL: rd_data_o = ctrl_q;
      default: if (|win_hit) rd_data_o = fn_rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ber_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i;
      if (err_i) ber_q <= 1'b1;
      else if (rd_done_i && addr_i == A_STAT) ber_q <= 1'b0;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign fn_addr_o  = addr_i;
  assign fn_wr_o    = wr_i && (|win_hit);
  assign fn_wdata_o = wdata_i;

  AST_BER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> ber_q); // R9
endmodule

// File: rtl/snr_por_attn.sv
module snr_por_attn #(
  parameter int POR_CYC = 144
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic bus_rst_i,
  input  logic bus_idle_i,
  output logic por_o,
  output logic attn_o
);
  localparam int PW = $clog2(POR_CYC + 1);

  logic [PW-1:0] cnt_q;
  logic          pend_q;

  assign por_o  = (cnt_q != PW'(POR_CYC));
  assign attn_o = pend_q && bus_idle_i && !por_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (por_o) cnt_q <= cnt_q + 1'b1;
      if (bus_rst_i)   pend_q <= 1'b0;
      else if (err_i)  pend_q <= 1'b1;
      else if (attn_o) pend_q <= 1'b0;
    end
  end

  AST_ATTN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |=> !attn_o); // R9
  AST_POR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_o |=> !por_o); // R1
endmodule

// File: rtl/snr_resp.sv
module snr_resp
  import snr_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                POR_CYC   = 144,
  parameter int                NUM_FUNC  = 2,
  parameter logic [DATA_W-1:0] MFG_ID    = 16'hA5C3,
  parameter logic [DATA_W-1:0] DEV_ID    = 16'h1123,
  parameter logic [DATA_W-1:0] CAP_FIXED = 16'h0021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        dev_num_i,
  input  logic              sym_vld_i,
  input  logic [2:0]        sym_i,
  input  logic              bus_idle_i,
  output logic              rst_drv_o,
  output logic              slot_drv_o,
  output logic              slot_bit_o,
  output logic              attn_o,
  output logic [DATA_W-1:0] ctrl_o,
  input  logic [6:0]        func_status_i,
  output logic [5:0]        fn_addr_o,
  output logic              fn_wr_o,
  output logic [DATA_W-1:0] fn_wdata_o,
  input  logic [DATA_W-1:0] fn_rdata_i
);
  sym_e              sym;
  logic              por, wr, rd_done, err, bus_rst;
  logic [REG_W-1:0]  addr;
  logic [DATA_W-1:0] wdata, rd_data;

  assign sym       = sym_e'(sym_i);
  assign rst_drv_o = por;

  snr_por_attn #(.POR_CYC(POR_CYC)) u_por (
    .clk_i, .rst_ni, .err_i(err), .bus_rst_i(bus_rst), .bus_idle_i,
    .por_o(por), .attn_o
  );

  snr_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni, .en_i(!por), .sym_vld_i, .sym_i(sym), .dev_num_i,
    .rd_data_i(rd_data), .addr_o(addr), .wr_o(wr), .wdata_o(wdata),
    .rd_done_o(rd_done), .err_o(err), .bus_rst_o(bus_rst),
    .slot_drv_o, .slot_bit_o
  );

  snr_regs #(
    .DATA_W(DATA_W), .NUM_FUNC(NUM_FUNC), .MFG_ID(MFG_ID),
    .DEV_ID(DEV_ID), .CAP_FIXED(CAP_FIXED)
  ) u_regs (
    .clk_i, .rst_ni, .dev_num_i, .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_done_i(rd_done), .err_i(err), .func_status_i, .fn_rdata_i,
    .rd_data_o(rd_data), .ctrl_o, .fn_addr_o, .fn_wr_o, .fn_wdata_o
  );

  AST_POR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_drv_o |-> (!slot_drv_o && !attn_o)); // R1
  AST_CTRL_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(sym_vld_i && sym_i == 3'd1, 2)); // R4
  AST_RSTSYM_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_vld_i && sym_i == 3'd4) |=> $stable(ctrl_o)); // R11
endmodule

// File: tb/tb_snr_resp.sv
module tb_snr_resp;
  localparam int POR_CYC = 144;
  localparam logic [2:0] D0 = 3'd0, D1 = 3'd1, ST = 3'd2, AT = 3'd3, RS = 3'd4;
  localparam logic [2:0] ME = 3'd5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  dev_num_i = ME;
  logic        sym_vld_i = 1'b0;
  logic [2:0]  sym_i = D0;
  logic        bus_idle_i = 1'b0;
  logic        rst_drv_o, slot_drv_o, slot_bit_o, attn_o, fn_wr_o;
  logic [15:0] ctrl_o, fn_wdata_o, fn_rdata_i;
  logic [6:0]  func_status_i = 7'h15;
  logic [5:0]  fn_addr_o;

  int total = 0, bad = 0, por_cnt = 0, fn_wr_cnt = 0;
  logic [5:0]  fn_last_addr;
  logic [15:0] fn_last_data;
  bit done = 0;

  always #5 clk = ~clk;

  assign fn_rdata_i = 16'h3C00 | {10'b0, fn_addr_o};

  snr_resp dut (
    .clk_i(clk), .rst_ni, .dev_num_i, .sym_vld_i, .sym_i, .bus_idle_i,
    .rst_drv_o, .slot_drv_o, .slot_bit_o, .attn_o, .ctrl_o, .func_status_i,
    .fn_addr_o, .fn_wr_o, .fn_wdata_o, .fn_rdata_i
  );

  always @(negedge clk) if (rst_ni && rst_drv_o) por_cnt++;
  always @(posedge clk) if (fn_wr_o) begin
    fn_wr_cnt    <= fn_wr_cnt + 1;
    fn_last_addr <= fn_addr_o;
    fn_last_data <= fn_wdata_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] s);
    @(negedge clk); sym_vld_i = 1'b1; sym_i = s;
    @(negedge clk); sym_vld_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [2:0] dev, input logic [5:0] a, input logic rw);
    send(ST);
    for (int i = 2; i >= 0; i--) send(dev[i] ? D1 : D0);
    for (int i = 5; i >= 0; i--) send(a[i] ? D1 : D0);
    send(rw ? D1 : D0);
  endtask

  task automatic rd(input logic [2:0] dev, input logic [5:0] a, input logic [2:0] ack,
                    output logic [15:0] data, output logic par, output int ndrv);
    send_hdr(dev, a, 1'b1);
    ndrv = 0;
    for (int i = 15; i >= 0; i--) begin
      if (slot_drv_o) ndrv++;
      data[i] = slot_drv_o && slot_bit_o;
      send(data[i] ? D1 : D0);
    end
    if (slot_drv_o) ndrv++;
    par = slot_drv_o && slot_bit_o;
    send(par ? D1 : D0);
    send(ack);
  endtask

  task automatic wr(input logic [2:0] dev, input logic [5:0] a, input logic [15:0] data,
                    input logic flip, input logic [2:0] ack, input int gap, input int attn_at,
                    output logic acked);
    send_hdr(dev, a, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      if (i == attn_at) send(AT);
      if (i == 8 && gap > 0) repeat (gap) @(negedge clk);
      send(data[i] ? D1 : D0);
    end
    send((^{dev, a, 1'b0, data} ^ flip) ? D1 : D0);
    acked = slot_drv_o && slot_bit_o;
    send(acked ? ack : D0);
  endtask

  task automatic attn_probe(input string req, input logic exp);
    @(negedge clk); #1;
    check({req, " attn low while bus busy"}, attn_o, 1'b0);
    @(negedge clk); bus_idle_i = 1'b1; #1;
    check({req, " attn on idle"}, attn_o, exp);
    @(negedge clk); bus_idle_i = 1'b0;
    @(negedge clk); bus_idle_i = 1'b1; #1;
    check({req, " attn single pulse"}, attn_o, 1'b0);
    @(negedge clk); bus_idle_i = 1'b0;
  endtask

  task automatic t_por;
    check("R1 reset rst_drv", rst_drv_o, 1'b1);
    check("R1 reset slot_drv", slot_drv_o, 1'b0);
    check("R1 reset ctrl", ctrl_o, 16'h0);
    @(posedge clk); #1 rst_ni = 1'b1;
    send_hdr(ME, 6'd5, 1'b1); // would leave a read in progress if not ignored
    while (rst_drv_o) @(negedge clk);
    check("R1 por length", por_cnt, POR_CYC);
    check("R1 symbols ignored during por", slot_drv_o, 1'b0);
  endtask

  task automatic t_map;
    logic [15:0] d; logic p; int n;
    logic [15:0] exp [6] = '{16'h0005, 16'hA5C3, 16'h1123, 16'h0021, 16'h0015, 16'h0000};
    for (int r = 0; r < 6; r++) begin
      rd(ME, 6'(r), D1, d, p, n);
      check($sformatf("R3 reg %0d value", r), d, exp[r]);
      check($sformatf("R3 reg %0d parity", r), p, ^{ME, 6'(r), 1'b1, exp[r]});
      check($sformatf("R3 reg %0d slots", r), n, 17);
    end
  endtask

  task automatic t_write;
    logic a; logic [15:0] d; logic p; int n;
    wr(ME, 6'd5, 16'h5A3C, 1'b0, D1, 0, -1, a);
    check("R4 ack driven", a, 1'b1);
    check("R4 ctrl updated", ctrl_o, 16'h5A3C);
    rd(ME, 6'd5, D1, d, p, n);
    check("R4 ctrl readback", d, 16'h5A3C);
  endtask

  task automatic t_bad_par;
    logic a;
    wr(ME, 6'd5, 16'h1111, 1'b1, D1, 0, -1, a);
    check("R5 no ack on bad parity", a, 1'b0);
    check("R5 ctrl kept", ctrl_o, 16'h5A3C);
  endtask

  task automatic t_reserved;
    logic a; logic [15:0] d; logic p; int n, c0;
    rd(ME, 6'd40, D1, d, p, n); check("R6 read 40 zero", d, 16'h0);
    rd(ME, 6'd7, D1, d, p, n);  check("R6 read 7 zero", d, 16'h0);
    rd(ME, 6'd24, D1, d, p, n); check("R6 read window3 zero", d, 16'h0);
    c0 = fn_wr_cnt;
    wr(ME, 6'd40, 16'hFFFF, 1'b0, D1, 0, -1, a);
    check("R6 reserved write acked", a, 1'b1);
    wr(ME, 6'd24, 16'hFFFF, 1'b0, D1, 0, -1, a);
    check("R6 window3 write acked", a, 1'b1);
    check("R6 ctrl untouched", ctrl_o, 16'h5A3C);
    check("R6 no function write", fn_wr_cnt, c0);
    rd(ME, 6'd40, D1, d, p, n); check("R6 read 40 still zero", d, 16'h0);
  endtask

  task automatic t_func;
    logic a; logic [15:0] d; logic p; int n, c0;
    c0 = fn_wr_cnt;
    wr(ME, 6'd9, 16'hC0DE, 1'b0, D1, 0, -1, a);
    check("R14 window write acked", a, 1'b1);
    check("R14 fn_wr pulses", fn_wr_cnt, c0 + 1);
    check("R14 fn addr", fn_last_addr, 6'd9);
    check("R14 fn data", fn_last_data, 16'hC0DE);
    rd(ME, 6'd10, D1, d, p, n);
    check("R14 window read", d, 16'h3C0A);
  endtask

  task automatic t_addr;
    logic a; logic [15:0] d; logic p; int n;
    rd(3'd2, 6'd1, D1, d, p, n);  check("R2 other dev read no drive", n, 0);
    rd(3'd0, 6'd1, D1, d, p, n);  check("R2 broadcast read no drive", n, 0);
    wr(3'd6, 6'd5, 16'h7777, 1'b0, D1, 0, -1, a);
    check("R2 other dev write no ack", a, 1'b0);
    check("R2 other dev write ctrl kept", ctrl_o, 16'h5A3C);
    wr(3'd0, 6'd5, 16'h0F0F, 1'b0, D1, 0, -1, a);
    check("R2 broadcast write acked", a, 1'b1);
    check("R2 broadcast write ctrl", ctrl_o, 16'h0F0F);
  endtask

  task automatic t_abort;
    logic a;
    send(ST); send(D1); send(D0); send(D1); send(D0); send(D1);
    wr(ME, 6'd5, 16'h1234, 1'b0, D1, 0, -1, a);
    check("R7 restarted frame acked", a, 1'b1);
    check("R7 restarted frame ctrl", ctrl_o, 16'h1234);
    attn_probe("R7", 1'b0);
  endtask

  task automatic t_gap;
    logic a;
    wr(ME, 6'd5, 16'hBEEF, 1'b0, D1, 3000, -1, a);
    check("R8 write after gap acked", a, 1'b1);
    check("R8 write after gap ctrl", ctrl_o, 16'hBEEF);
  endtask

  task automatic t_rd_nack;
    logic [15:0] d; logic p; int n;
    rd(ME, 6'd1, D0, d, p, n);
    attn_probe("R9", 1'b1);
    rd(ME, 6'd4, D1, d, p, n);
    check("R12 status shows bus error", d, 16'h0095);
    rd(ME, 6'd4, D1, d, p, n);
    check("R12 bus error cleared", d, 16'h0015);
  endtask

  task automatic t_wr_disrupt;
    logic a; logic [15:0] d; logic p; int n;
    wr(ME, 6'd5, 16'hDEAD, 1'b0, AT, 0, -1, a);
    check("R10 ack was driven", a, 1'b1);
    check("R10 no commit", ctrl_o, 16'hBEEF);
    attn_probe("R10", 1'b1);
    rd(ME, 6'd4, D1, d, p, n);
    check("R10 bus error set", d, 16'h0095);
  endtask

  task automatic t_busrst;
    logic [15:0] d; logic p; int n;
    send_hdr(ME, 6'd5, 1'b0);
    for (int i = 0; i < 4; i++) send(D1);
    send(RS);
    check("R11 ctrl kept after reset", ctrl_o, 16'hBEEF);
    for (int i = 0; i < 13; i++) send(D0); // rest of the stale frame
    check("R11 stale frame not acked", slot_drv_o, 1'b0);
    send(D1);
    check("R11 stale frame no write", ctrl_o, 16'hBEEF);
    rd(ME, 6'd5, D1, d, p, n);
    check("R11 register kept", d, 16'hBEEF);
  endtask

  task automatic t_attn_skip;
    logic a;
    wr(ME, 6'd5, 16'h0ACE, 1'b0, D1, 0, 3, a);
    check("R13 frame with attn acked", a, 1'b1);
    check("R13 frame with attn ctrl", ctrl_o, 16'h0ACE);
  endtask

  initial begin
    t_por();
    t_map();
    t_write();
    t_bad_par();
    t_reserved();
    t_func();
    t_addr();
    t_abort();
    t_gap();
    t_rd_nack();
    t_wr_disrupt();
    t_busrst();
    t_attn_skip();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule